// File: doc/BRIEF.md
# Multi-Mode Framed Serial PCM Port

This block is one serial port on a time-division multiplexed PCM bus. A frame is 32 eight-bit timeslots long, and each bit lasts two clock cycles, so a frame takes 512 cycles. A frame pulse marks where each frame begins. The pulse is active low in one convention (`fp_gci_i = 0`) and active high in the other (`fp_gci_i = 1`).

The port takes its sample out of the serial input stream and hands it to a processing core as a parallel word with a one-cycle strobe. It serialises the core's transmit word into the matching timeslots. In the mode that carries the D and C signalling channels, it copies those two channels from the serial input back to the serial output. In every timeslot the current mode does not use, the output enable is dropped.

The 2-bit `mode_i` selects the timeslot layout, and the port samples it at each frame start:
- `00`: one 8-bit sample in timeslot 0.
- `01`: one 8-bit sample in timeslot 2.
- `10`: one 8-bit sample in timeslot 2, with D and C bypass in timeslots 0 and 1.
- `11`: one 16-bit linear sample spread over timeslots 0 and 1.

Top module: `tdm_pcm_port`

## Requirements
- R1: A frame starts at the first clock edge that samples the frame pulse inactive after an edge that sampled it active. The active level is low when `fp_gci_i`=0 and high when `fp_gci_i`=1. The cycle after that edge is cycle 0 of the frame. Cycle c lies in timeslot c/16, bit cell (c%16)/2.
- R2: After reset, and until the first frame start, `ser_oe_o` and `rx_valid_o` stay 0 whatever `ser_i` carries.
- R3: In mode `00`, timeslot 0 carries `tx_word_i[7:0]` out, and the byte received in timeslot 0 is returned in `rx_word_o` as {8'h00, byte}.
- R4: In mode `01`, the same exchange as in R3 happens in timeslot 2 instead of timeslot 0.
- R5: In mode `10`, timeslot 2 behaves as in R4. The bytes received in timeslots 0 and 1 of a mode-`10` frame are sent unchanged in timeslots 0 and 1 of the next frame. Until such a frame has been received, timeslots 0 and 1 send zeros, which is the reset value.
- R6: In mode `11`, timeslots 0 and 1 together carry `tx_word_i[15:0]` out, bit 15 (the sign) first. The 16 bits received in those two timeslots appear in `rx_word_o` with the first received bit as bit 15.
- R7: Each byte is sent most significant bit first. The output holds each bit for both cycles of its cell. The input is captured at the clock edge that ends the first cycle of each cell.
- R8: Outside the timeslots the mode uses, `ser_oe_o` and `ser_o` are 0, and input bits there do not change `rx_word_o`.
- R9: `rx_valid_o` is high for exactly one cycle, namely cycle 16·s+15, where s is the last timeslot of the sample. `rx_word_o` holds the new sample in that cycle.
- R10: `mode_i` and `tx_word_i` are captured at each frame start. Changes to them later in the frame have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, two cycles per data bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse |
| fp_gci_i | input | 1 | Frame pulse polarity: 1 = active high, 0 = active low |
| mode_i | input | 2 | Timeslot layout select |
| tx_word_i | input | 16 | Transmit word from the core |
| ser_i | input | 1 | Serial data in |
| ser_o | output | 1 | Serial data out |
| ser_oe_o | output | 1 | Output enable for the serial pin driver |
| rx_word_o | output | 16 | Received sample for the core |
| rx_valid_o | output | 1 | One-cycle strobe that marks a new `rx_word_o` |

## Verification
Both serial output pins depend only on the frame counter and on state latched at the frame start. They are therefore due in the same cycle as the frame position, so the bench compares them once in the middle of every cycle of the frame. An input bit that the bench places in cycle c is registered at the edge that ends cycle c. The receive strobe therefore appears one cycle later, in cycle 16·s+15, and the bench expects it in that cycle and in no other. The bytes bypassed in mode `10` appear one frame later, so the bench carries the expected D and C bytes forward from one frame to the next.

// File: rtl/tdm_pcm_port.sv
module tdm_pcm_port #(
  parameter int SLOTS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fp_i,
  input  logic        fp_gci_i,
  input  logic [1:0]  mode_i,
  input  logic [15:0] tx_word_i,
  input  logic        ser_i,
  output logic        ser_o,
  output logic        ser_oe_o,
  output logic [15:0] rx_word_o,
  output logic        rx_valid_o
);
  localparam int FRAME_CYC = SLOTS * 16;
  localparam int CW = $clog2(FRAME_CYC);
  localparam int SW = CW - 4;
  localparam logic [1:0] M_SLOT0 = 2'b00, M_SLOT2 = 2'b01, M_DC = 2'b10, M_LIN = 2'b11;

  logic          fp_q, synced;
  logic [CW-1:0] cnt;
  logic [1:0]    mode_q;
  logic [15:0]   tx_q, dc_q, rx_sr;
  logic [7:0]    d_q, c_q;

  wire          fp_act = fp_gci_i ? fp_i : ~fp_i;
  wire          sof    = fp_q & ~fp_act;
  wire [SW-1:0] slot   = cnt[CW-1:4];
  wire [2:0]    bitn   = cnt[3:1];
  wire [3:0]    idx16  = {slot[0], bitn};
  wire          in_s0  = slot == SW'(0);
  wire          in_s1  = slot == SW'(1);
  wire          in_s2  = slot == SW'(2);

  wire samp = ((mode_q == M_SLOT0) & in_s0)
            | (((mode_q == M_SLOT2) | (mode_q == M_DC)) & in_s2)
            | ((mode_q == M_LIN) & (in_s0 | in_s1));
  wire byp  = (mode_q == M_DC) & (in_s0 | in_s1);
  wire act  = synced & (samp | byp);

  wire tx_bit = byp                ? dc_q[4'd15 - idx16] :
                (mode_q == M_LIN)  ? tx_q[4'd15 - idx16] :
                                     tx_q[3'd7 - bitn];

  assign ser_o    = act & tx_bit;
  assign ser_oe_o = act;

  wire        cap   = act & ~sof & ~cnt[0];
  wire        last  = bitn == 3'd7;
  wire [15:0] sr_nx = {rx_sr[14:0], ser_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q       <= 1'b0;
      synced     <= 1'b0;
      cnt        <= '0;
      mode_q     <= M_SLOT0;
      tx_q       <= '0;
      dc_q       <= '0;
      rx_sr      <= '0;
      d_q        <= '0;
      c_q        <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      fp_q       <= fp_act;
      rx_valid_o <= 1'b0;
      if (sof) begin
        cnt    <= '0;
        synced <= 1'b1;
        mode_q <= mode_i;
        tx_q   <= tx_word_i;
        dc_q   <= {d_q, c_q};
      end else begin
        cnt <= (cnt == CW'(FRAME_CYC - 1)) ? '0 : cnt + CW'(1);
      end
      if (cap) begin
        rx_sr <= sr_nx;
        if (last) begin
          if (byp) begin
            if (in_s0) d_q <= sr_nx[7:0];
            else       c_q <= sr_nx[7:0];
          end else if (mode_q == M_LIN) begin
            if (in_s1) begin
              rx_word_o  <= sr_nx;
              rx_valid_o <= 1'b1;
            end
          end else begin
            rx_word_o  <= {8'h00, sr_nx[7:0]};
            rx_valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_pcm_port_chk.sv
module tdm_pcm_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cnt_lo,
  input logic       sof,
  input logic       synced,
  input logic [1:0] mode_q,
  input logic       ser_o,
  input logic       ser_oe_o,
  input logic       rx_valid_o
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |=> !rx_valid_o); // R9
  AST_VALID_AT_CELL_END: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |-> cnt_lo == 4'hF); // R9
  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !synced |-> !ser_oe_o && !rx_valid_o); // R2
  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !ser_oe_o |-> !ser_o); // R8
  AST_BIT_HELD_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n) cnt_lo[0] |-> $stable(ser_o) && $stable(ser_oe_o)); // R7
  AST_MODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !sof |=> $stable(mode_q)); // R10
endmodule

bind tdm_pcm_port tdm_pcm_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_lo(cnt[3:0]), .sof(sof), .synced(synced),
  .mode_q(mode_q), .ser_o(ser_o), .ser_oe_o(ser_oe_o), .rx_valid_o(rx_valid_o)
);

// File: tb/test_tdm_pcm_port.sv
module test_tdm_pcm_port;
  localparam int CLK_NS = 244;

  logic clk = 1'b0, rst_n = 1'b0, fp_i = 1'b1, fp_gci_i = 1'b0, ser_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [15:0] tx_word_i = '0;
  logic ser_o, ser_oe_o, rx_valid_o;
  logic [15:0] rx_word_o;
  int checks = 0, fails = 0;
  logic [7:0] dc_next_d = '0, dc_next_c = '0;

  always #(CLK_NS / 2) clk = ~clk;

  tdm_pcm_port i_tdm_pcm_port (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .fp_gci_i(fp_gci_i), .mode_i(mode_i),
    .tx_word_i(tx_word_i), .ser_i(ser_i), .ser_o(ser_o), .ser_oe_o(ser_oe_o),
    .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  function automatic logic [7:0] pat(int s, int seed);
    return 8'((s * 37 + seed * 11 + 90) % 256);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // R1: frame pulse at the active level for one edge, then inactive
  task automatic pulse();
    @(negedge clk) fp_i = fp_gci_i;
    @(negedge clk) fp_i = ~fp_gci_i;
  endtask

  task automatic run_frame(logic [1:0] m, logic [15:0] tx, int seed, bit disturb, string req);
    logic [15:0] dc, exp_rx;
    dc = {dc_next_d, dc_next_c};
    exp_rx = (m == 2'b11) ? {pat(0, seed), pat(1, seed)} :
             (m == 2'b00) ? {8'h00, pat(0, seed)} : {8'h00, pat(2, seed)};
    mode_i = m; tx_word_i = tx;
    pulse();
    for (int c = 0; c < 512; c++) begin
      int s, b;
      logic [7:0] by;
      bit samp, byp, ex_oe, ex_bit, ex_v;
      @(negedge clk);
      s = c / 16; b = (c % 16) / 2;
      by = pat(s, seed);
      ser_i = by[7 - b];
      if (disturb && c == 100) begin mode_i = ~m; tx_word_i = ~tx; end
      samp = (m == 2'b00 && s == 0) || ((m == 2'b01 || m == 2'b10) && s == 2) ||
             (m == 2'b11 && s < 2);
      byp = (m == 2'b10) && s < 2;
      ex_oe = samp || byp;
      if (byp)             ex_bit = dc[15 - ((s % 2) * 8 + b)];
      else if (m == 2'b11) ex_bit = tx[15 - (s * 8 + b)];
      else                 ex_bit = tx[7 - b];
      chk(ser_oe_o == ex_oe, ex_oe ? req : "R8", "oe", {15'b0, ser_oe_o}, {15'b0, ex_oe});
      if (ex_oe) chk(ser_o == ex_bit, req, "R7/bit", {15'b0, ser_o}, {15'b0, ex_bit});
      else       chk(ser_o == 1'b0, "R8", "idle ser_o", {15'b0, ser_o}, 16'h0);
      ex_v = (c % 16 == 15) && ((m == 2'b00 && s == 0) || (m == 2'b11 && s == 1) ||
             ((m == 2'b01 || m == 2'b10) && s == 2));
      chk(rx_valid_o == ex_v, "R9", "rx_valid", {15'b0, rx_valid_o}, {15'b0, ex_v});
      if (ex_v) chk(rx_word_o == exp_rx, req, "rx_word", rx_word_o, exp_rx);
    end
    if (m == 2'b10) begin dc_next_d = pat(0, seed); dc_next_c = pat(1, seed); end
  endtask

  task automatic test_reset();
    int bad = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      ser_i = i[1];
      if (ser_oe_o || rx_valid_o || ser_o) bad++;
    end
    chk(bad == 0, "R2", "pre-sync activity cycles", 16'(bad), 16'h0);
    chk(rx_word_o == 16'h0, "R2", "rx_word after reset", rx_word_o, 16'h0);
  endtask

  task automatic test_mode1();  run_frame(2'b00, 16'h12A5, 1, 0, "R3"); run_frame(2'b00, 16'hFF3C, 2, 0, "R3"); endtask
  task automatic test_mode2();  run_frame(2'b01, 16'h0096, 3, 0, "R4"); endtask
  task automatic test_mode3();  run_frame(2'b10, 16'h00C3, 4, 0, "R5"); run_frame(2'b10, 16'h005A, 5, 0, "R5");
                                run_frame(2'b10, 16'h0011, 6, 0, "R5"); endtask
  task automatic test_mode4();  run_frame(2'b11, 16'h8001, 7, 0, "R6"); run_frame(2'b11, 16'h7E5B, 8, 0, "R6"); endtask
  task automatic test_latch();  run_frame(2'b11, 16'hC0DE, 9, 1, "R10"); run_frame(2'b00, 16'h4477, 10, 1, "R10"); endtask
  task automatic test_gci();
    @(negedge clk); fp_gci_i = 1'b1; fp_i = 1'b0;
    run_frame(2'b00, 16'h00E7, 11, 0, "R1");
    run_frame(2'b11, 16'hA55A, 12, 0, "R1");
    run_frame(2'b10, 16'h0033, 13, 0, "R1");
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_mode1();
    test_mode2();
    test_mode3();
    test_mode4();
    test_latch();
    test_gci();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule